// File: doc/BRIEF.md
# Configurable Asynchronous-Control Register Cell

This block is one bit of storage as it appears inside a programmable logic element. On the clocked side it captures a data input on the rising clock edge when a clock enable is high. Alongside the clock path, two active-high asynchronous control lines are shared by the cell. A static three-bit mode selects how these lines act on the flip-flop's internal preset and clear nodes. The cell can act as plain clear, preset, preset with clear, or an asynchronous load of a separate load-value input, with or without an extra clear or preset.

The cell has no true preset path in the load-with-preset mode. There, preset is built from the clear node by inverting the register's input and output. The stored bit is then the complement of what the output shows, and the load value is complemented before it reaches the nodes. When both internal nodes are active at once, clear wins. An active-low reset clears the stored bit. In the inverted mode the output therefore shows 1 after reset.

Top module: `cfg_async_cell`

## Requirements
- R1: While rst_n is low, q is 0 in every mode except mode 4, where q is 1.
- R2: With no asynchronous action active, a rising clk edge with en=1 makes q equal to d; with en=0, q holds its value.
- R3: Mode 0 (clear only): ctl_a=1 or ctl_b=1 drives q to 0.
- R4: Mode 1 (preset): ctl_a=1 drives q to 1; ctl_b has no effect.
- R5: Mode 2 (preset and clear): ctl_b=1 drives q to 0; otherwise ctl_a=1 drives q to 1.
- R6: Mode 3 (load with clear): ctl_b=1 drives q to 0; otherwise ctl_a=1 drives q to load_val.
- R7: Mode 4 (load with preset, inverted storage): ctl_b=1 drives q to 1; otherwise ctl_a=1 drives q to load_val.
- R8: Mode 5 (load only): ctl_a=1 drives q to load_val; ctl_b has no effect.
- R9: Modes 6 and 7 ignore ctl_a and ctl_b entirely; only the clocked path changes q.
- R10: While an asynchronous action is active, clock edges do not change q, whatever d and en are.
- R11: Asynchronous actions take effect at once, between clock edges, and q keeps the value after the control lines drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the stored bit |
| mode | input | 3 | Static selection of the asynchronous behaviour, encoded as in R3 to R9 |
| en | input | 1 | Clock enable for capture of d |
| d | input | 1 | Clocked data input |
| load_val | input | 1 | Value written by an asynchronous load |
| ctl_a | input | 1 | First asynchronous control line, active high |
| ctl_b | input | 1 | Second asynchronous control line, active high |
| q | output | 1 | Register output |

## Verification
The bench goes through every mode and every combination of the two control lines and the load value. It applies each combination half a cycle away from a clock edge and checks q one time unit later, so a design that waited for the clock to apply an asynchronous action fails straight away. A clock edge with the opposite d is then given while the controls are held. A design that let the clock win, or that gave preset priority over clear when both nodes fire in the load modes, shows the wrong level there. In the load modes the load value is toggled while ctl_a stays high, which catches a design that latches only the first load. Mode 4 with ctl_b checks for the missing inversion, because a correct cell shows 1 and a broken one shows 0.

// File: rtl/cfg_async_cell.sv
module cfg_async_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       en,
  input  logic       d,
  input  logic       load_val,
  input  logic       ctl_a,
  input  logic       ctl_b,
  output logic       q
);
  localparam logic [2:0] M_CLR    = 3'd0;
  localparam logic [2:0] M_PRE    = 3'd1;
  localparam logic [2:0] M_PRECLR = 3'd2;
  localparam logic [2:0] M_LDCLR  = 3'd3;
  localparam logic [2:0] M_LDPRE  = 3'd4;
  localparam logic [2:0] M_LD     = 3'd5;

  logic inv;
  logic pre_n, clr_n;
  logic clr_all;
  logic stored;

  assign inv = (mode == M_LDPRE);

  always_comb begin
    pre_n = 1'b0;
    clr_n = 1'b0;
    case (mode)
      M_CLR:    clr_n = ctl_a | ctl_b;
      M_PRE:    pre_n = ctl_a;
      M_PRECLR: begin pre_n = ctl_a; clr_n = ctl_b; end
      M_LDCLR:  begin pre_n = ctl_a & load_val;  clr_n = (ctl_a & ~load_val) | ctl_b; end
      M_LDPRE:  begin pre_n = ctl_a & ~load_val; clr_n = (ctl_a & load_val) | ctl_b; end
      M_LD:     begin pre_n = ctl_a & load_val;  clr_n = ctl_a & ~load_val; end
      default:  begin pre_n = 1'b0; clr_n = 1'b0; end
    endcase
  end

  assign clr_all = clr_n | ~rst_n;

  always_ff @(posedge clk or posedge clr_all or posedge pre_n) begin
    if (clr_all)      stored <= 1'b0;
    else if (pre_n)   stored <= 1'b1;
    else if (en)      stored <= d ^ inv;
  end

  assign q = stored ^ inv;
endmodule

module cfg_async_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       en,
  input logic       d,
  input logic       load_val,
  input logic       ctl_a,
  input logic       ctl_b,
  input logic       q
);
  a_r1_reset_level: assert property (@(posedge clk)
    !rst_n |-> q == (mode == 3'd4));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11 && en) |=> q == $past(d));

  a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && (ctl_a || ctl_b)) |-> !q);

  a_r4_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && ctl_a) |-> q);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && ctl_b) |-> !q);

  a_r7_inverted_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && ctl_b) |-> q);

  a_r8_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && ctl_a) |-> q == load_val);

  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11 && !en) |=> $stable(q));
endmodule

bind cfg_async_cell cfg_async_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .en(en), .d(d),
  .load_val(load_val), .ctl_a(ctl_a), .ctl_b(ctl_b), .q(q)
);

// File: tb/cfg_async_cell_test.sv
module cfg_async_cell_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       en = 1'b0, d = 1'b0, load_val = 1'b0, ctl_a = 1'b0, ctl_b = 1'b0;
  logic       q;

  int    tests = 0, fails = 0;
  logic  exp_q = 1'b0;
  logic  run = 1'b0;
  logic  done = 1'b0;
  string cur_req = "R2";

  cfg_async_cell uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .en(en), .d(d),
    .load_val(load_val), .ctl_a(ctl_a), .ctl_b(ctl_b), .q(q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void async_eval(output logic act, output logic val);
    act = 1'b0; val = 1'b0;
    case (mode)
      3'd0: if (ctl_a || ctl_b) begin act = 1; val = 0; end
      3'd1: if (ctl_a) begin act = 1; val = 1; end
      3'd2: if (ctl_b) begin act = 1; val = 0; end else if (ctl_a) begin act = 1; val = 1; end
      3'd3: if (ctl_b) begin act = 1; val = 0; end else if (ctl_a) begin act = 1; val = load_val; end
      3'd4: if (ctl_b) begin act = 1; val = 1; end else if (ctl_a) begin act = 1; val = load_val; end
      3'd5: if (ctl_a) begin act = 1; val = load_val; end
      default: act = 0;
    endcase
  endfunction

  task automatic settle();
    logic a, v;
    async_eval(a, v);
    if (!rst_n) exp_q = (mode == 3'd4);
    else if (a) exp_q = v;
  endtask

  always @(posedge clk) begin
    logic a, v;
    async_eval(a, v);
    if (rst_n && !a && en) exp_q = d;
  end

  task automatic check(input string req);
    tests++;
    if (q !== exp_q) begin
      fails++;
      $display("FAIL %s: mode=%0d q=%b expected %b at %0t", req, mode, q, exp_q, $time);
    end
  endtask

  always @(negedge clk) if (run && !done) check(cur_req);

  task automatic mid();
    @(negedge clk); #2;
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      mid();
      rst_n = 0; ctl_a = 0; ctl_b = 0; en = 0; mode = m[2:0];
      settle(); #1;
      mid();
      check("R1");
      run = 1'b1;
      rst_n = 1; settle();
      cur_req = "R2";
      en = 1; d = 1; mid();
      d = 0; mid();
      en = 0; d = 1; mid();
      mid();
      for (int k = 1; k < 8; k++) begin
        for (int p = 0; p < 2; p++) begin
          cur_req = "R2";
          en = 1; d = p[0]; mid();
          {ctl_a, ctl_b, load_val} = k[2:0];
          d = ~p[0];
          settle(); #1;
          check({mode_req(m), "/R11"});
          cur_req = "R10";
          mid();
          ctl_a = 0; ctl_b = 0; en = 0;
          settle(); #1;
          check("R11");
          cur_req = "R2";
          mid();
        end
      end
      if (m >= 3 && m <= 5) begin
        en = 0; ctl_a = 1; load_val = 0; settle(); #1;
        check(mode_req(m));
        #2 load_val = 1; settle(); #1;
        check(mode_req(m));
        #2 load_val = 0; settle(); #1;
        check(mode_req(m));
        mid();
        ctl_a = 0; settle(); #1;
        check("R11");
      end
    end
    mid();
    finish_run();
  end
endmodule